// File: doc/BRIEF.md
# USB Suspend/Resume Power-Management Register Block

This block is the small register file that software uses to manage the power states of a USB device function. It has two registers, which a CPU-side strobe bus writes and reads. The control register holds the master enable, the clock gate for the function's 48 MHz clock, and the line-driver supply and current settings. It also holds a selector for which default state the function adopts. The status register holds sticky flags: suspend seen, resume interrupt, resume detect and wake-up timing error. It also holds the remote wake-up bit, which software sets to ask for resume signalling toward the host.

Bus-state logic sends single-cycle suspend and resume detection pulses, and these set the sticky flags. Software clears a flag by writing 0 to its bit. A remote wake-up leaves the suspend flag alone, so software must clear that flag itself. A 1 kHz tick input measures how long the wake-up bit stays set. If software drops the bit before 10 ms have passed, or leaves it set past 15 ms, the block raises a timing-error flag. When software clears the master enable, every register in the block returns to its reset value, and the block holds the function in soft reset.

Top module: `usb_pm_regs`

## Requirements
- R1: After hardware reset, both registers read 0x00, the soft-reset output is 1, and the clock gate, line-driver and resume-request outputs are 0.
- R2: The control register is at address 0. Its bit 7 is the master enable, bit 5 is the clock gate, bit 4 is the line-driver supply, bit 3 selects low current (1) or high current (0), and bit 1 selects the default state after a bus reset (1) or after power-on (0). The matching outputs follow the register one cycle after the write.
- R3: Control bits 0, 2 and 6 always read 0, and writing 1 to them has no effect.
- R4: The low-current output is 1 only while both the supply bit and the current bit are 1.
- R5: Writing the control register with bit 7 = 0 clears all control and status bits at that same edge. While bit 7 is 0, the soft-reset output is 1, and detection pulses and status writes are ignored.
- R6: The status register is at address 1. Bit 0 is the suspend flag, bit 1 is the resume interrupt, bit 2 is resume detect, bit 3 is the remote wake-up bit and bit 4 is the wake timing error. Bits 5 to 7 read 0. Writing 0 to bit 0, 1 or 4 clears that flag, and writing 1 leaves it unchanged.
- R7: A suspend pulse sets bit 0, and a resume pulse sets both bit 1 and bit 2, at the next clock edge.
- R8: Clearing the resume interrupt clears resume detect at the same edge. Resume detect cannot be cleared or set by a write of its own.
- R9: When a detection pulse and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: The resume-request output equals the wake-up bit. Setting or clearing the wake-up bit does not change the suspend flag.
- R11: If software clears the wake-up bit after fewer than 10 ticks have arrived since it was set, the timing-error flag is set.
- R12: If a tick arrives after 15 ticks have already been counted with the wake-up bit still set, the timing-error flag is set.
- R13: Addresses 2 and 3 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| susp_det_pulse | input | 1 | One-cycle pulse when suspend is detected |
| res_det_pulse | input | 1 | One-cycle pulse when resume is detected |
| ms_tick | input | 1 | One-cycle 1 kHz time-base pulse |
| resume_req | output | 1 | Request for resume signalling toward the host |
| usb_clk_en | output | 1 | Clock gate enable for the function clock |
| drv_supply_en | output | 1 | Line-driver supply enable |
| drv_low_current | output | 1 | Line driver in low-current mode |
| dflt_after_busreset | output | 1 | Default state follows a bus reset |
| usb_soft_rst | output | 1 | Block-wide soft reset, active high |
| resume_irq | output | 1 | Resume interrupt flag |
| wake_timing_err | output | 1 | Wake-up duration violation flag |

## Verification
The assertions assume that the detection pulses and ticks are each one cycle wide. They also assume that addresses and write data are stable around the rising edge, so a pulse in a given cycle counts as exactly one event. The bench drives every input on the falling edge and releases each strobe one nanosecond after the next rising edge, so each pulse covers exactly one capture edge. Cases where a pulse and a software clear meet on the same cycle, and the disable write, are driven on purpose to reach the priority and override paths.

// File: rtl/usb_pm_pkg.sv
package usb_pm_pkg;

  localparam int DATA_W    = 8;

  // control register bit positions
  localparam int CB_EN     = 7;
  localparam int CB_CLK    = 5;
  localparam int CB_DRV    = 4;
  localparam int CB_LOWI   = 3;
  localparam int CB_DFLT   = 1;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << CB_EN) | (1 << CB_CLK) | (1 << CB_DRV) | (1 << CB_LOWI) | (1 << CB_DFLT));

  // status register bit positions
  localparam int SB_SUSP   = 0;
  localparam int SB_RIRQ   = 1;
  localparam int SB_RDET   = 2;
  localparam int SB_RWU    = 3;
  localparam int SB_WERR   = 4;

  typedef struct packed {
    logic werr;
    logic rwu;
    logic rdet;
    logic rirq;
    logic susp;
  } pm_flags_t;

  // value the control register takes on a write
  function automatic logic [DATA_W-1:0] ctrl_next(input logic [DATA_W-1:0] wd);
    return wd[CB_EN] ? (wd & CTRL_MASK) : '0;
  endfunction

  // sticky flag: set has priority over clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input pm_flags_t f);
    logic [DATA_W-1:0] v;
    v = '0;
    v[SB_SUSP] = f.susp;
    v[SB_RIRQ] = f.rirq;
    v[SB_RDET] = f.rdet;
    v[SB_RWU]  = f.rwu;
    v[SB_WERR] = f.werr;
    return v;
  endfunction

endpackage

// File: rtl/usb_pm_ctrl_reg.sv
module usb_pm_ctrl_reg
  import usb_pm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              kill_wr
);

  logic ctrl_wr;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign kill_wr = ctrl_wr && !wdata[CB_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_next(wdata);
    end
  end

endmodule

// File: rtl/usb_pm_wake_timer.sv
module usb_pm_wake_timer #(
  parameter int MIN_MS = 10,
  parameter int MAX_MS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rwu,
  input  logic rwu_sw_clr,
  input  logic tick,
  output logic early_viol,
  output logic late_viol
);

  localparam int CNT_W = $clog2(MAX_MS + 2);

  logic [CNT_W-1:0] cnt;

  assign early_viol = rwu_sw_clr && (cnt < CNT_W'(MIN_MS));
  assign late_viol  = rwu && tick && (cnt == CNT_W'(MAX_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!rwu) begin
      cnt <= '0;
    end else if (tick && (cnt <= CNT_W'(MAX_MS))) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/usb_pm_flags.sv
module usb_pm_flags
  import usb_pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      st_wr,
  input  logic      wd_susp,
  input  logic      wd_rirq,
  input  logic      wd_rwu,
  input  logic      wd_werr,
  input  logic      susp_pulse,
  input  logic      res_pulse,
  input  logic      early_viol,
  input  logic      late_viol,
  output pm_flags_t flags,
  output logic      rwu_sw_clr,
  output logic      susp_sw_clr
);

  logic irq_clr, err_clr, viol;

  assign susp_sw_clr = st_wr && !wd_susp && !hold;
  assign irq_clr     = st_wr && !wd_rirq;
  assign err_clr     = st_wr && !wd_werr;
  assign rwu_sw_clr  = st_wr && !wd_rwu && flags.rwu && !hold;
  assign viol        = early_viol || late_viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (hold) begin
      flags <= '0;
    end else begin
      flags.susp <= sticky_next(flags.susp, susp_pulse, susp_sw_clr);
      flags.rirq <= sticky_next(flags.rirq, res_pulse, irq_clr);
      flags.rdet <= sticky_next(flags.rdet, res_pulse, irq_clr);
      flags.rwu  <= st_wr ? wd_rwu : flags.rwu;
      flags.werr <= sticky_next(flags.werr, viol, err_clr);
    end
  end

endmodule

// File: rtl/usb_pm_regs.sv
module usb_pm_regs
  import usb_pm_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int MIN_MS    = 10,
  parameter int MAX_MS    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              susp_det_pulse,
  input  logic              res_det_pulse,
  input  logic              ms_tick,
  output logic              resume_req,
  output logic              usb_clk_en,
  output logic              drv_supply_en,
  output logic              drv_low_current,
  output logic              dflt_after_busreset,
  output logic              usb_soft_rst,
  output logic              resume_irq,
  output logic              wake_timing_err
);

  logic [DATA_W-1:0] ctrl_q;
  logic              kill_wr;
  logic              hold;
  logic              st_wr;
  pm_flags_t         flags;
  logic              rwu_sw_clr;
  logic              susp_sw_clr;
  logic              early_viol;
  logic              late_viol;

  // named events for the checker
  logic susp_flag;
  logic res_det;

  usb_pm_ctrl_reg #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .ctrl_q (ctrl_q),
    .kill_wr(kill_wr)
  );

  assign hold  = !ctrl_q[CB_EN] || kill_wr;
  assign st_wr = wr_en && (addr == ADDR_W'(STAT_ADDR));

  usb_pm_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .st_wr      (st_wr),
    .wd_susp    (wdata[SB_SUSP]),
    .wd_rirq    (wdata[SB_RIRQ]),
    .wd_rwu     (wdata[SB_RWU]),
    .wd_werr    (wdata[SB_WERR]),
    .susp_pulse (susp_det_pulse),
    .res_pulse  (res_det_pulse),
    .early_viol (early_viol),
    .late_viol  (late_viol),
    .flags      (flags),
    .rwu_sw_clr (rwu_sw_clr),
    .susp_sw_clr(susp_sw_clr)
  );

  usb_pm_wake_timer #(
    .MIN_MS(MIN_MS),
    .MAX_MS(MAX_MS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rwu       (flags.rwu),
    .rwu_sw_clr(rwu_sw_clr),
    .tick      (ms_tick),
    .early_viol(early_viol),
    .late_viol (late_viol)
  );

  always_comb begin
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdata = ctrl_q;
    end else if (addr == ADDR_W'(STAT_ADDR)) begin
      rdata = pack_status(flags);
    end else begin
      rdata = '0;
    end
  end

  assign susp_flag           = flags.susp;
  assign res_det             = flags.rdet;
  assign resume_req          = flags.rwu;
  assign resume_irq          = flags.rirq;
  assign wake_timing_err     = flags.werr;
  assign usb_clk_en          = ctrl_q[CB_CLK];
  assign drv_supply_en       = ctrl_q[CB_DRV];
  assign drv_low_current     = ctrl_q[CB_DRV] & ctrl_q[CB_LOWI];
  assign dflt_after_busreset = ctrl_q[CB_DFLT];
  assign usb_soft_rst        = !ctrl_q[CB_EN];

endmodule

// File: rtl/usb_pm_chk.sv
module usb_pm_chk #(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              usb_soft_rst,
  input logic              resume_req,
  input logic              resume_irq,
  input logic              wake_timing_err,
  input logic              susp_flag,
  input logic              res_det,
  input logic              kill_wr,
  input logic              susp_sw_clr,
  input logic              late_viol,
  input logic              susp_det_pulse,
  input logic              res_det_pulse
);

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CTRL_ADDR)) |-> (rdata[0] == 1'b0 && rdata[2] == 1'b0 && rdata[6] == 1'b0));

  assert_disabled_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    usb_soft_rst |-> (!resume_req && !resume_irq && !wake_timing_err && !susp_flag));

  assert_resume_sets_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_det_pulse && !usb_soft_rst && !kill_wr) |=> (res_det && resume_irq));

  assert_det_needs_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_det |-> resume_irq);

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_det_pulse && !usb_soft_rst && !kill_wr) |=> susp_flag);

  assert_susp_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_flag && !susp_sw_clr && !kill_wr) |=> susp_flag);

  assert_late_flags_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (late_viol && !usb_soft_rst && !kill_wr) |=> wake_timing_err);

endmodule

bind usb_pm_regs usb_pm_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .addr           (addr),
  .rdata          (rdata),
  .usb_soft_rst   (usb_soft_rst),
  .resume_req     (resume_req),
  .resume_irq     (resume_irq),
  .wake_timing_err(wake_timing_err),
  .susp_flag      (susp_flag),
  .res_det        (res_det),
  .kill_wr        (kill_wr),
  .susp_sw_clr    (susp_sw_clr),
  .late_viol      (late_viol),
  .susp_det_pulse (susp_det_pulse),
  .res_det_pulse  (res_det_pulse)
);

// File: tb/tb_usb_pm_regs.sv
module tb_usb_pm_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       susp_det_pulse = 1'b0;
  logic       res_det_pulse = 1'b0;
  logic       ms_tick = 1'b0;
  logic [7:0] rdata;
  logic       resume_req, usb_clk_en, drv_supply_en, drv_low_current;
  logic       dflt_after_busreset, usb_soft_rst, resume_irq, wake_timing_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_out;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  usb_pm_regs dut (
    .clk                (clk),
    .rst_n              (rst_n),
    .wr_en              (wr_en),
    .addr               (addr),
    .wdata              (wdata),
    .rdata              (rdata),
    .susp_det_pulse     (susp_det_pulse),
    .res_det_pulse      (res_det_pulse),
    .ms_tick            (ms_tick),
    .resume_req         (resume_req),
    .usb_clk_en         (usb_clk_en),
    .drv_supply_en      (drv_supply_en),
    .drv_low_current    (drv_low_current),
    .dflt_after_busreset(dflt_after_busreset),
    .usb_soft_rst       (usb_soft_rst),
    .resume_irq         (resume_irq),
    .wake_timing_err    (wake_timing_err)
  );

  // outputs packed {req, clk, supply, lowI, dflt, softrst, irq, err}
  function automatic logic [7:0] out_vec();
    return {resume_req, usb_clk_en, drv_supply_en, drv_low_current,
            dflt_after_busreset, usb_soft_rst, resume_irq, wake_timing_err};
  endfunction

  // monitor: pops expected items and compares after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        act = it.is_out ? out_vec() : rdata;
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit s, input bit r, input bit t);
    @(negedge clk);
    susp_det_pulse = s; res_det_pulse = r; ms_tick = t;
    @(posedge clk); #1;
    susp_det_pulse = 1'b0; res_det_pulse = 1'b0; ms_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(1'b0, 1'b0, 1'b1);
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_out = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #3;
  endtask

  task automatic exp_out(input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_out = 1'b1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #3;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    exp_rd(2'd0, 8'h00, "R1 ctrl after reset");
    exp_rd(2'd1, 8'h00, "R1 status after reset");
    exp_out(8'h04, "R1 outputs after reset");

    // R2 R3 control layout and reserved bits
    wr(2'd0, 8'hFF);
    exp_rd(2'd0, 8'hBA, "R3 reserved bits read zero");
    exp_out(8'h78, "R2 outputs follow control");

    // R4 current mode masked while supply disabled
    wr(2'd0, 8'hA8);
    exp_rd(2'd0, 8'hA8, "R2 ctrl readback");
    exp_out(8'h40, "R4 low current needs supply");

    // R7 suspend pulse
    pulse(1'b1, 1'b0, 1'b0);
    exp_rd(2'd1, 8'h01, "R7 suspend flag set");

    // R10 wake-up leaves suspend, R11 boundary: 10 ticks is fine
    wr(2'd1, 8'h09);
    exp_rd(2'd1, 8'h09, "R10 wake bit set, suspend kept");
    exp_out(8'hC0, "R10 resume request out");
    ticks(10);
    wr(2'd1, 8'h01);
    exp_rd(2'd1, 8'h01, "R10 suspend kept after wake clear, R11 no error at 10");

    // R7 R8 resume flags
    pulse(1'b0, 1'b1, 1'b0);
    exp_rd(2'd1, 8'h07, "R7 resume sets irq and detect");
    exp_out(8'h42, "R7 resume irq output");
    wr(2'd1, 8'h01);
    exp_rd(2'd1, 8'h01, "R8 irq clear also clears detect");

    // R6 clear suspend by writing 0
    wr(2'd1, 8'h00);
    exp_rd(2'd1, 8'h00, "R6 suspend cleared");

    // R8 detect bit not writable
    wr(2'd1, 8'h04);
    exp_rd(2'd1, 8'h00, "R8 detect bit write ignored");

    // R11 early clear
    wr(2'd1, 8'h08);
    ticks(9);
    wr(2'd1, 8'h00);
    exp_rd(2'd1, 8'h10, "R11 early clear flags error");
    exp_out(8'h41, "R11 error output");
    wr(2'd1, 8'h00);
    exp_rd(2'd1, 8'h00, "R6 error cleared");

    // R12 late
    wr(2'd1, 8'h08);
    ticks(15);
    exp_rd(2'd1, 8'h08, "R12 no error at 15 ticks");
    ticks(1);
    exp_rd(2'd1, 8'h18, "R12 error after 16th tick");
    wr(2'd1, 8'h00);
    exp_rd(2'd1, 8'h00, "R12 error and wake cleared");

    // R9 set beats clear in same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h00; susp_det_pulse = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; susp_det_pulse = 1'b0;
    exp_rd(2'd1, 8'h01, "R9 pulse wins over clear");

    // R5 master disable
    pulse(1'b0, 1'b1, 1'b0);
    wr(2'd1, 8'h0B);
    exp_rd(2'd1, 8'h0F, "R5 flags before disable");
    wr(2'd0, 8'h3A);
    exp_rd(2'd0, 8'h00, "R5 ctrl cleared by disable");
    exp_rd(2'd1, 8'h00, "R5 status cleared by disable");
    exp_out(8'h04, "R5 outputs after disable");
    pulse(1'b1, 1'b1, 1'b0);
    exp_rd(2'd1, 8'h00, "R5 pulses ignored while disabled");
    wr(2'd1, 8'h08);
    exp_rd(2'd1, 8'h00, "R5 status write ignored while disabled");

    // R13 unmapped addresses
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hFF);
    exp_rd(2'd2, 8'h00, "R13 addr 2 reads zero");
    exp_rd(2'd3, 8'h00, "R13 addr 3 reads zero");
    exp_rd(2'd0, 8'hA0, "R13 ctrl untouched");
    exp_rd(2'd1, 8'h00, "R13 status untouched");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule